// File: doc/BRIEF.md
# Tagged-Operand Reservation Station

This block is a small pool of waiting slots that sits in front of one class of functional unit in an out-of-order core. An instruction arrives with its operation code and two source operands that have already been renamed. Each operand comes either as a finished value or as the tag of the unit or slot that will produce it. The instruction takes the lowest free slot. If no slot is free the request is refused, and the issue logic must hold it.

Every busy slot watches a shared result bus that carries a 64-bit value and a 4-bit producer tag. A pending operand whose stored tag matches the bus tag takes the bus value in that cycle. A slot whose two operands are both present is offered to the functional unit. The lowest-numbered ready slot is offered first, one slot per cycle. Once the unit accepts a slot, that slot is not offered again. The slot stays occupied until the bus carries its own tag, and then it becomes free. A flush empties every slot at once.

Top module: `rs_station`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, every slot is free: `alloc_ready` is 1, `alloc_tag` equals TAG_BASE, and `disp_valid` is 0. Flush takes priority over allocation and broadcast in the same cycle.
- R2: `alloc_ready` is 0 exactly when all NUM_ENT slots are busy. An `alloc_valid` pulse while `alloc_ready` is 0 creates no slot. That instruction is never offered at the dispatch port.
- R3: `alloc_tag` equals TAG_BASE plus the index of the lowest free slot. An accepted allocation fills that slot, and its result is identified by that tag.
- R4: An operand whose source tag is 0 is valid at allocation. The value supplied with it is used unchanged.
- R5: A pending operand with nonzero source tag T takes `cdb_data` at the first clock edge where `cdb_valid` is 1 and `cdb_tag` equals T. That value is then presented at the dispatch port.
- R6: If an allocation carries source tag T in the same cycle that the bus broadcasts T, the operand takes the bus value and does not wait for a later broadcast.
- R7: A slot is offered (`disp_valid` = 1 with its tag on `disp_tag`) only when both of its operands are valid.
- R8: Among the ready slots, the one with the lowest index is offered. It stays offered until a cycle where `fu_ready` is 1, and after that it is never offered again.
- R9: A busy slot becomes free at the clock edge where the bus carries `cdb_valid` = 1 with that slot's own tag. From the next cycle it can be allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clears all slots |
| alloc_valid | input | 1 | Allocation request |
| alloc_op | input | 4 | Operation code of the new instruction |
| alloc_tag_a | input | 4 | Source tag of operand A, 0 = value present |
| alloc_val_a | input | 64 | Value of operand A when its tag is 0 |
| alloc_tag_b | input | 4 | Source tag of operand B, 0 = value present |
| alloc_val_b | input | 64 | Value of operand B when its tag is 0 |
| alloc_ready | output | 1 | A free slot exists |
| alloc_tag | output | 4 | Tag the next accepted instruction receives |
| cdb_valid | input | 1 | Result bus carries a value |
| cdb_tag | input | 4 | Producer tag on the result bus |
| cdb_data | input | 64 | Value on the result bus |
| fu_ready | input | 1 | Functional unit accepts the offered slot |
| disp_valid | output | 1 | A ready slot is offered |
| disp_tag | output | 4 | Tag of the offered slot |
| disp_op | output | 4 | Operation of the offered slot |
| disp_a | output | 64 | Operand A of the offered slot |
| disp_b | output | 64 | Operand B of the offered slot |

## Verification
A slot whose busy or issued state is wrong shows up at once on `alloc_ready` and `alloc_tag`, or as an offer that appears twice or is missing on the dispatch port. The bench's reference model catches it in the next cycle. A wrongly captured operand, or a capture missed at allocation, stays hidden until that slot is offered. It then appears as a wrong `disp_a` or `disp_b`, or as a slot that is never offered. For that reason every scenario drains the pool through the dispatch port. Priority errors show up as a different `disp_tag` in any cycle with two or more slots ready.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int RS_DATA_W = 64;
  parameter int RS_TAG_W  = 4;
  parameter int RS_OP_W   = 4;

  typedef logic [RS_DATA_W-1:0] data_t;
  typedef logic [RS_TAG_W-1:0]  tag_t;
  typedef logic [RS_OP_W-1:0]   op_t;

  typedef struct packed {
    logic  rdy;
    tag_t  tag;
    data_t val;
  } operand_t;

  typedef struct packed {
    logic     busy;
    logic     issued;
    op_t      op;
    operand_t a;
    operand_t b;
  } slot_t;

  // Operand as written at allocation: tag 0 is a value, a live broadcast fills it.
  function automatic operand_t make_operand(tag_t t, data_t v, logic cv, tag_t ct, data_t cd);
    operand_t o;
    o.tag = t;
    if (t == '0) begin
      o.rdy = 1'b1;
      o.val = v;
    end else if (cv && (ct == t)) begin
      o.rdy = 1'b1;
      o.val = cd;
    end else begin
      o.rdy = 1'b0;
      o.val = v;
    end
    return o;
  endfunction

  // Snoop of a waiting operand.
  function automatic operand_t snoop_operand(operand_t cur, logic cv, tag_t ct, data_t cd);
    operand_t o;
    o = cur;
    if (!cur.rdy && cv && (ct == cur.tag)) begin
      o.rdy = 1'b1;
      o.val = cd;
    end
    return o;
  endfunction
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pkg::*;
#(
  parameter int OWN_TAG = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  logic  alloc_en,
  input  op_t   alloc_op,
  input  tag_t  alloc_tag_a,
  input  data_t alloc_val_a,
  input  tag_t  alloc_tag_b,
  input  data_t alloc_val_b,
  input  logic  cdb_valid,
  input  tag_t  cdb_tag,
  input  data_t cdb_data,
  input  logic  issue_en,
  output logic  busy,
  output logic  ready,
  output op_t   op,
  output data_t val_a,
  output data_t val_b
);
  slot_t cur, nxt;
  logic  upd;
  logic  own_hit;

  assign own_hit = cdb_valid && (cdb_tag == tag_t'(OWN_TAG));

  always_comb begin
    nxt = cur;
    upd = flush | cur.busy | alloc_en;
    if (flush) begin
      nxt.busy   = 1'b0;
      nxt.issued = 1'b0;
    end else if (cur.busy) begin
      if (own_hit) begin
        nxt.busy   = 1'b0;
        nxt.issued = 1'b0;
      end else begin
        nxt.a = snoop_operand(cur.a, cdb_valid, cdb_tag, cdb_data);
        nxt.b = snoop_operand(cur.b, cdb_valid, cdb_tag, cdb_data);
        if (issue_en) nxt.issued = 1'b1;
      end
    end else if (alloc_en) begin
      nxt.busy   = 1'b1;
      nxt.issued = 1'b0;
      nxt.op     = alloc_op;
      nxt.a      = make_operand(alloc_tag_a, alloc_val_a, cdb_valid, cdb_tag, cdb_data);
      nxt.b      = make_operand(alloc_tag_b, alloc_val_b, cdb_valid, cdb_tag, cdb_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur.busy   <= 1'b0;
      cur.issued <= 1'b0;
    end else if (upd) begin
      cur <= nxt;
    end
  end

  assign busy  = cur.busy;
  assign ready = cur.busy && !cur.issued && cur.a.rdy && cur.b.rdy;
  assign op    = cur.op;
  assign val_a = cur.a.val;
  assign val_b = cur.b.val;
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
#(
  parameter int NUM_ENT  = 4,
  parameter int TAG_BASE = 1,
  localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 alloc_valid,
  input  logic [RS_OP_W-1:0]   alloc_op,
  input  logic [RS_TAG_W-1:0]  alloc_tag_a,
  input  logic [RS_DATA_W-1:0] alloc_val_a,
  input  logic [RS_TAG_W-1:0]  alloc_tag_b,
  input  logic [RS_DATA_W-1:0] alloc_val_b,
  output logic                 alloc_ready,
  output logic [RS_TAG_W-1:0]  alloc_tag,
  input  logic                 cdb_valid,
  input  logic [RS_TAG_W-1:0]  cdb_tag,
  input  logic [RS_DATA_W-1:0] cdb_data,
  input  logic                 fu_ready,
  output logic                 disp_valid,
  output logic [RS_TAG_W-1:0]  disp_tag,
  output logic [RS_OP_W-1:0]   disp_op,
  output logic [RS_DATA_W-1:0] disp_a,
  output logic [RS_DATA_W-1:0] disp_b
);
  logic [NUM_ENT-1:0] busy_vec, rdy_vec, free_gnt, disp_gnt, alloc_en, issue_en;
  logic [IW-1:0]      free_idx, disp_idx;
  op_t                s_op  [NUM_ENT];
  data_t              s_a   [NUM_ENT];
  data_t              s_b   [NUM_ENT];
  logic               alloc_fire;

  rs_pick #(.N(NUM_ENT)) u_free_pick (
    .req(~busy_vec), .gnt(free_gnt), .idx(free_idx), .any(alloc_ready)
  );

  rs_pick #(.N(NUM_ENT)) u_disp_pick (
    .req(rdy_vec), .gnt(disp_gnt), .idx(disp_idx), .any(disp_valid)
  );

  assign alloc_fire = alloc_valid && alloc_ready && !flush;
  assign alloc_tag  = tag_t'(TAG_BASE) + tag_t'(free_idx);
  assign alloc_en   = alloc_fire ? free_gnt : '0;
  assign issue_en   = fu_ready ? disp_gnt : '0;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_slot
    rs_slot #(.OWN_TAG(TAG_BASE + i)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .alloc_en    (alloc_en[i]),
      .alloc_op    (alloc_op),
      .alloc_tag_a (alloc_tag_a),
      .alloc_val_a (alloc_val_a),
      .alloc_tag_b (alloc_tag_b),
      .alloc_val_b (alloc_val_b),
      .cdb_valid   (cdb_valid),
      .cdb_tag     (cdb_tag),
      .cdb_data    (cdb_data),
      .issue_en    (issue_en[i]),
      .busy        (busy_vec[i]),
      .ready       (rdy_vec[i]),
      .op          (s_op[i]),
      .val_a       (s_a[i]),
      .val_b       (s_b[i])
    );
  end

  always_comb begin
    disp_op = '0;
    disp_a  = '0;
    disp_b  = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      disp_op = disp_op | (s_op[i] & {RS_OP_W{disp_gnt[i]}});
      disp_a  = disp_a  | (s_a[i]  & {RS_DATA_W{disp_gnt[i]}});
      disp_b  = disp_b  | (s_b[i]  & {RS_DATA_W{disp_gnt[i]}});
    end
  end

  assign disp_tag = tag_t'(TAG_BASE) + tag_t'(disp_idx);
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk
  import rs_pkg::*;
#(
  parameter int NUM_ENT  = 4,
  parameter int TAG_BASE = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               alloc_ready,
  input logic [RS_TAG_W-1:0] alloc_tag,
  input logic               cdb_valid,
  input logic [RS_TAG_W-1:0] cdb_tag,
  input logic               fu_ready,
  input logic               disp_valid,
  input logic [RS_TAG_W-1:0] disp_tag,
  input logic [NUM_ENT-1:0] busy_vec,
  input logic [NUM_ENT-1:0] disp_gnt
);
  // R1
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (alloc_ready && !disp_valid && busy_vec == '0));

  // R2
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ready) == (&busy_vec));

  // R3
  tag_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ready |-> !busy_vec[alloc_tag - RS_TAG_W'(TAG_BASE)]);

  // R8
  one_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(disp_gnt) && (disp_valid == (disp_gnt != '0)));

  // R8
  no_reoffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && fu_ready && !flush) |=> !(disp_valid && disp_tag == $past(disp_tag)));

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_rel
    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && busy_vec[i] && cdb_tag == RS_TAG_W'(TAG_BASE + i)) |=> !busy_vec[i]);
  end
endmodule

bind rs_station rs_station_chk #(.NUM_ENT(NUM_ENT), .TAG_BASE(TAG_BASE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .alloc_ready(alloc_ready),
  .alloc_tag  (alloc_tag),
  .cdb_valid  (cdb_valid),
  .cdb_tag    (cdb_tag),
  .fu_ready   (fu_ready),
  .disp_valid (disp_valid),
  .disp_tag   (disp_tag),
  .busy_vec   (busy_vec),
  .disp_gnt   (disp_gnt)
);

// File: tb/tb_rs_station.sv
module tb_rs_station;
  localparam int N  = 4;
  localparam int TB = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush, alloc_valid, cdb_valid, fu_ready;
  logic [3:0]  alloc_op, alloc_tag_a, alloc_tag_b, cdb_tag;
  logic [63:0] alloc_val_a, alloc_val_b, cdb_data;
  logic        alloc_ready, disp_valid;
  logic [3:0]  alloc_tag, disp_tag, disp_op;
  logic [63:0] disp_a, disp_b;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rs_station #(.NUM_ENT(N), .TAG_BASE(TB)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_op(alloc_op),
    .alloc_tag_a(alloc_tag_a), .alloc_val_a(alloc_val_a),
    .alloc_tag_b(alloc_tag_b), .alloc_val_b(alloc_val_b),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .fu_ready(fu_ready), .disp_valid(disp_valid), .disp_tag(disp_tag),
    .disp_op(disp_op), .disp_a(disp_a), .disp_b(disp_b)
  );

  // Behavioural reference: one record per slot.
  bit          m_busy [N];
  bit          m_iss  [N];
  int          m_op   [N];
  bit          m_ar   [N];
  bit          m_br   [N];
  int          m_at   [N];
  int          m_bt   [N];
  logic [63:0] m_av   [N];
  logic [63:0] m_bv   [N];

  function automatic int lowest_free();
    for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  function automatic int lowest_ready();
    for (int i = 0; i < N; i++)
      if (m_busy[i] && !m_iss[i] && m_ar[i] && m_br[i]) return i;
    return -1;
  endfunction

  task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_model();
    int f;
    int r;
    f = lowest_free();
    r = lowest_ready();
    check_eq("R2", "alloc_ready", 64'(alloc_ready), 64'(f >= 0));
    if (f >= 0) check_eq("R3", "alloc_tag", 64'(alloc_tag), 64'(f + TB));
    check_eq("R7", "disp_valid", 64'(disp_valid), 64'(r >= 0));
    if (r >= 0) begin
      check_eq("R8", "disp_tag", 64'(disp_tag), 64'(r + TB));
      check_eq("R8", "disp_op", 64'(disp_op), 64'(m_op[r]));
      check_eq("R5", "disp_a", disp_a, m_av[r]);
      check_eq("R5", "disp_b", disp_b, m_bv[r]);
    end
  endtask

  task automatic model_step();
    int f;
    int r;
    f = lowest_free();
    r = lowest_ready();
    if (flush) begin
      for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_iss[i] = 0; end
      return;
    end
    for (int i = 0; i < N; i++) begin
      if (!m_busy[i]) continue;
      if (cdb_valid && cdb_tag == 4'(i + TB)) begin
        m_busy[i] = 0;
        m_iss[i]  = 0;
      end else begin
        if (!m_ar[i] && cdb_valid && cdb_tag == 4'(m_at[i])) begin m_ar[i] = 1; m_av[i] = cdb_data; end
        if (!m_br[i] && cdb_valid && cdb_tag == 4'(m_bt[i])) begin m_br[i] = 1; m_bv[i] = cdb_data; end
        if (i == r && fu_ready) m_iss[i] = 1;
      end
    end
    if (alloc_valid && f >= 0) begin
      m_busy[f] = 1; m_iss[f] = 0; m_op[f] = alloc_op;
      m_at[f] = alloc_tag_a; m_bt[f] = alloc_tag_b;
      m_ar[f] = (alloc_tag_a == 0) || (cdb_valid && cdb_tag == alloc_tag_a);
      m_av[f] = (alloc_tag_a == 0) ? alloc_val_a : cdb_data;
      m_br[f] = (alloc_tag_b == 0) || (cdb_valid && cdb_tag == alloc_tag_b);
      m_bv[f] = (alloc_tag_b == 0) ? alloc_val_b : cdb_data;
    end
  endtask

  // One cycle: drive after the falling edge, compare, advance the model.
  task automatic cyc(bit av, int op, int ta, logic [63:0] va, int tb_, logic [63:0] vb,
                     bit cv, int ct, logic [63:0] cd, bit fu, bit fl);
    alloc_valid = av; alloc_op = 4'(op);
    alloc_tag_a = 4'(ta); alloc_val_a = va;
    alloc_tag_b = 4'(tb_); alloc_val_b = vb;
    cdb_valid = cv; cdb_tag = 4'(ct); cdb_data = cd;
    fu_ready = fu; flush = fl;
    #1;
    compare_model();
    model_step();
    @(negedge clk);
  endtask

  task automatic idle(bit fu);
    cyc(0, 0, 0, 64'h0, 0, 64'h0, 0, 0, 64'h0, fu, 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    flush = 0; alloc_valid = 0; cdb_valid = 0; fu_ready = 0;
    alloc_op = 0; alloc_tag_a = 0; alloc_tag_b = 0; cdb_tag = 0;
    alloc_val_a = 0; alloc_val_b = 0; cdb_data = 0;
    for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_iss[i] = 0; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check_eq("R1", "alloc_ready", 64'(alloc_ready), 64'd1);
    check_eq("R1", "alloc_tag", 64'(alloc_tag), 64'(TB));
    check_eq("R1", "disp_valid", 64'(disp_valid), 64'd0);
    @(negedge clk);
    idle(0);

    // R4: both operands given as values
    cyc(1, 3, 0, 64'd10, 0, 64'd20, 0, 0, 64'h0, 0, 0);
    #1;
    check_eq("R4", "disp_a", disp_a, 64'd10);
    check_eq("R4", "disp_b", disp_b, 64'd20);
    // R7: B waits on external tag 9
    cyc(1, 5, 0, 64'd7, 9, 64'hDEAD, 0, 0, 64'h0, 0, 0);
    #1;
    check_eq("R3", "alloc_tag", 64'(alloc_tag), 64'd3);
    check_eq("R7", "disp_tag", 64'(disp_tag), 64'd1);
    // R5: broadcast tag 9; slot 1 accepted this cycle
    cyc(0, 0, 0, 64'h0, 0, 64'h0, 1, 9, 64'h99, 1, 0);
    #1;
    check_eq("R5", "disp_b", disp_b, 64'h99);
    check_eq("R8", "disp_tag", 64'(disp_tag), 64'd2);
    idle(1);
    #1;
    check_eq("R8", "disp_valid after accept", 64'(disp_valid), 64'd0);
    // R9: release slot 1 by its own tag
    cyc(0, 0, 0, 64'h0, 0, 64'h0, 1, 1, 64'h111, 0, 0);
    #1;
    check_eq("R9", "alloc_tag", 64'(alloc_tag), 64'd1);
    // R6: alloc with A on tag 11 while 11 is broadcast
    cyc(1, 6, 11, 64'hDEAD, 12, 64'hBEEF, 1, 11, 64'hAB, 0, 0);
    #1;
    check_eq("R7", "disp_valid B pending", 64'(disp_valid), 64'd0);
    cyc(0, 0, 0, 64'h0, 0, 64'h0, 1, 12, 64'hCD, 0, 0);
    #1;
    check_eq("R6", "disp_a", disp_a, 64'hAB);
    check_eq("R5", "disp_b", disp_b, 64'hCD);
    // Fill the pool: slot 3 waits on slot 2's result, slot 4 ready
    cyc(1, 7, 2, 64'hDEAD, 0, 64'd5, 0, 0, 64'h0, 0, 0);
    cyc(1, 8, 0, 64'd1, 0, 64'd2, 0, 0, 64'h0, 0, 0);
    #1;
    check_eq("R2", "alloc_ready full", 64'(alloc_ready), 64'd0);
    // R2: refused allocation
    cyc(1, 15, 0, 64'hF00, 0, 64'hF00, 0, 0, 64'h0, 0, 0);
    // release slot 2; slot 3 captures its A from the same broadcast
    cyc(0, 0, 0, 64'h0, 0, 64'h0, 1, 2, 64'h22, 0, 0);
    #1;
    check_eq("R9", "alloc_tag", 64'(alloc_tag), 64'd2);
    repeat (3) idle(1);
    #1;
    check_eq("R2", "refused op never offered", 64'(disp_valid), 64'd0);
    // R1 flush with pending allocation and broadcast
    cyc(1, 9, 0, 64'd1, 0, 64'd1, 1, 3, 64'h0, 0, 1);
    #1;
    check_eq("R1", "alloc_ready", 64'(alloc_ready), 64'd1);
    check_eq("R1", "alloc_tag", 64'(alloc_tag), 64'(TB));
    check_eq("R1", "disp_valid", 64'(disp_valid), 64'd0);
    cyc(1, 4, 0, 64'd33, 0, 64'd44, 0, 0, 64'h0, 0, 0);
    cyc(1, 2, 1, 64'hDEAD, 0, 64'd1, 0, 0, 64'h0, 1, 0);
    cyc(0, 0, 0, 64'h0, 0, 64'h0, 1, 1, 64'h77, 0, 0);
    repeat (2) idle(1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule